// File: doc/BRIEF.md
# 10-bit Line Character Decoder with Violation Flag

This block sits behind a deserializer and word aligner. It takes one aligned 10-bit transmission character per transfer and returns the 8-bit value it carries. It also returns a flag that separates control characters from data characters, and a single violation flag. The violation flag is raised for two kinds of problem: a character that cannot be produced by an 8b/10b encoder at all, and a valid character whose disparity does not match the running disparity the decoder holds. Because a disparity fault shows up only when a later character disagrees with the tracked state, the flag can appear one or more characters after the corrupted one. After any character, flagged or not, the running disparity is rebuilt from the bits that were actually received. This lets decoding settle again after a fault.

A plain mode input selects unencoded operation. In that mode the ten received bits go straight to the outputs without decoding, and the running disparity is left alone.

Both streams use valid/ready handshakes and have one output register. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so a stalled consumer stalls the producer with no loss. While `out_valid` is high and `out_ready` is low, the output holds unchanged.

Top module: `sym10_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and the running disparity is negative. A character in its negative-disparity form is then accepted, and its positive form is flagged.
- R2: `in_code` bit 9 is line bit a and bit 0 is line bit j. The 6-bit block abcdei is `in_code[9:4]` and the 4-bit block fghj is `in_code[3:0]`. A valid data character Dx.y returns `out_data = {y[2:0], x[4:0]}`, `out_ctrl = 0` and `out_err = 0`.
- R3: The twelve control characters K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 return their value the same way as R2, with `out_ctrl = 1` and `out_err = 0`.
- R4: Any 10-bit pattern that no encoder can emit raises `out_err`. Examples are a 6-bit block with five or more equal bits, a 4-bit block of 0000 or 1111, or a Dx.7 that uses the wrong one of its two 4-bit forms.
- R5: A valid character in the disparity form opposite to the current running disparity raises `out_err`. If an earlier bit error flipped the tracked disparity, the flag lands on the first later character that disagrees with it.
- R6: Running disparity advances per block. A block with more ones than zeros makes it positive, and one with more zeros makes it negative. 000111 and 0011 make it positive, 111000 and 1100 make it negative, and any other balanced block keeps it.
- R7: After a flagged character, the running disparity is the R6 result over the received bits. A following character that is correct for that state decodes without error.
- R8: When `raw_mode` is 1 at acceptance, the output is `out_ctrl = in_code[9]`, `out_data = in_code[8:1]` and `out_err = in_code[0]`.
- R9: A character accepted on an edge is presented on the outputs with `out_valid = 1` right after that same edge (one register stage).
- R10: While `out_valid` is 1 and `out_ready` is 0, the outputs stay stable and `in_ready` is 0. No accepted character is lost or duplicated.
- R11: A character accepted in raw mode does not change the running disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_mode | input | 1 | 1: pass 10 bits through undecoded |
| in_valid | input | 1 | Input character present |
| in_ready | output | 1 | Block can take a character this cycle |
| in_code | input | 10 | Aligned character, bit 9 = a, bit 0 = j |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 8 | Decoded byte or raw bits 8..1 |
| out_ctrl | output | 1 | Control-character flag or raw bit 9 |
| out_err | output | 1 | Violation flag or raw bit 0 |

## Verification
The hardest case to reach is a late disparity error. A single flipped bit turns one valid character into another valid one of opposite disparity. Nothing is flagged then, and the fault appears only when a later unbalanced character disagrees. The stimulus builds this directly: a neutral D21.1 is corrupted into D21.0, then a neutral D10.2 is sent, and then an unbalanced D0.0 in the form the transmitter would have used. Random traffic, with illegal characters injected under back-pressure, covers the recovery of the running disparity. A bench encoder that follows the disparity implied by the received bits predicts the expected value of every following character.

// File: rtl/sym10_pkg.sv
`timescale 1ns/1ps
package sym10_pkg;
  localparam int CODE_W = 10;
  localparam int BYTE_W = 8;
  localparam int B6_W   = 6;
  localparam int B4_W   = 4;
  localparam int NUM_X  = 1 << (B6_W - 1);
  localparam int NUM_Y  = 1 << (B4_W - 1);
  localparam int X_W    = $clog2(NUM_X);
  localparam int Y_W    = $clog2(NUM_Y);

  // 6-bit block for data index x, given running disparity (1 = positive)
  function automatic logic [B6_W-1:0] enc6(input logic [X_W-1:0] x, input logic rdp);
    logic [B6_W-1:0] n;
    case (x)
      5'd0:  n = 6'b100111;  5'd1:  n = 6'b011101;
      5'd2:  n = 6'b101101;  5'd3:  n = 6'b110001;
      5'd4:  n = 6'b110101;  5'd5:  n = 6'b101001;
      5'd6:  n = 6'b011001;  5'd7:  n = 6'b111000;
      5'd8:  n = 6'b111001;  5'd9:  n = 6'b100101;
      5'd10: n = 6'b010101;  5'd11: n = 6'b110100;
      5'd12: n = 6'b001101;  5'd13: n = 6'b101100;
      5'd14: n = 6'b011100;  5'd15: n = 6'b010111;
      5'd16: n = 6'b011011;  5'd17: n = 6'b100011;
      5'd18: n = 6'b010011;  5'd19: n = 6'b110010;
      5'd20: n = 6'b001011;  5'd21: n = 6'b101010;
      5'd22: n = 6'b011010;  5'd23: n = 6'b111010;
      5'd24: n = 6'b110011;  5'd25: n = 6'b100110;
      5'd26: n = 6'b010110;  5'd27: n = 6'b110110;
      5'd28: n = 6'b001110;  5'd29: n = 6'b101110;
      5'd30: n = 6'b011110;  default: n = 6'b101011;
    endcase
    if (rdp && (($countones(n) != 3) || (n == 6'b111000))) n = ~n;
    return n;
  endfunction

  function automatic logic [B6_W-1:0] enc6_k28(input logic rdp);
    return rdp ? 6'b110000 : 6'b001111;
  endfunction

  // 4-bit block for data index y, given disparity after the 6-bit block
  function automatic logic [B4_W-1:0] enc4d(input logic [Y_W-1:0] y, input logic rdp);
    logic [B4_W-1:0] n;
    case (y)
      3'd0: n = 4'b1011; 3'd1: n = 4'b1001; 3'd2: n = 4'b0101; 3'd3: n = 4'b1100;
      3'd4: n = 4'b1101; 3'd5: n = 4'b1010; 3'd6: n = 4'b0110; default: n = 4'b1110;
    endcase
    if (rdp && (($countones(n) != 2) || (n == 4'b1100))) n = ~n;
    return n;
  endfunction

  // 4-bit block following K28, given disparity after the 6-bit block
  function automatic logic [B4_W-1:0] enc4k(input logic [Y_W-1:0] y, input logic rdp);
    logic [B4_W-1:0] n;
    case (y)
      3'd0: n = 4'b1011; 3'd1: n = 4'b0110; 3'd2: n = 4'b1010; 3'd3: n = 4'b1100;
      3'd4: n = 4'b1101; 3'd5: n = 4'b0101; 3'd6: n = 4'b1001; default: n = 4'b0111;
    endcase
    return rdp ? ~n : n;
  endfunction

  // alternate form of the y=7 block
  function automatic logic [B4_W-1:0] enc4alt(input logic rdp);
    return rdp ? 4'b1000 : 4'b0111;
  endfunction

  // data x values whose y=7 must use the alternate form at this disparity
  function automatic logic alt_needed(input logic [X_W-1:0] x, input logic rdp);
    if (rdp) return (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
    else     return (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
  endfunction

  function automatic logic alt_ctrl_x(input logic [X_W-1:0] x);
    return (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
  endfunction

  function automatic logic rd_step6(input logic [B6_W-1:0] s, input logic prev);
    int ones;
    ones = $countones(s);
    if (ones > 3)             return 1'b1;
    else if (ones < 3)        return 1'b0;
    else if (s == 6'b000111)  return 1'b1;
    else if (s == 6'b111000)  return 1'b0;
    else                      return prev;
  endfunction

  function automatic logic rd_step4(input logic [B4_W-1:0] s, input logic prev);
    int ones;
    ones = $countones(s);
    if (ones > 2)           return 1'b1;
    else if (ones < 2)      return 1'b0;
    else if (s == 4'b0011)  return 1'b1;
    else if (s == 4'b1100)  return 1'b0;
    else                    return prev;
  endfunction
endpackage

// File: rtl/sym10_blk6_match.sv
`timescale 1ns/1ps
module sym10_blk6_match
  import sym10_pkg::*;
(
  input  logic [B6_W-1:0] blk,
  input  logic            rd,
  output logic [NUM_X-1:0] hit,
  output logic            k28,
  output logic [X_W-1:0]  idx,
  output logic            rd_mid
);
  for (genvar gi = 0; gi < NUM_X; gi++) begin : g_cmp
    assign hit[gi] = (blk == enc6(X_W'(gi), rd));
  end

  assign k28    = (blk == enc6_k28(rd));
  assign rd_mid = rd_step6(blk, rd);

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_X; i++)
      if (hit[i]) idx = idx | X_W'(i);
  end

  // R2: a 6-bit block names at most one data index, and never also K28
  always_comb begin
    p_unique6_r2: assert ($onehot0(hit) && !(k28 && (|hit)));
  end
endmodule

// File: rtl/sym10_blk4_match.sv
`timescale 1ns/1ps
module sym10_blk4_match
  import sym10_pkg::*;
(
  input  logic [B4_W-1:0]  blk,
  input  logic             rd_mid,
  output logic [NUM_Y-1:0] dhit,
  output logic [NUM_Y-1:0] khit,
  output logic             alt_hit
);
  for (genvar gj = 0; gj < NUM_Y; gj++) begin : g_cmp
    assign dhit[gj] = (blk == enc4d(Y_W'(gj), rd_mid));
    assign khit[gj] = (blk == enc4k(Y_W'(gj), rd_mid));
  end

  assign alt_hit = (blk == enc4alt(rd_mid));

  // R3: each 4-bit table gives at most one index
  always_comb begin
    p_unique4_r3: assert ($onehot0(dhit) && $onehot0(khit) && !(alt_hit && dhit[NUM_Y-1]));
  end
endmodule

// File: rtl/sym10_char_decode.sv
`timescale 1ns/1ps
module sym10_char_decode
  import sym10_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              rd,
  output logic [BYTE_W-1:0] value,
  output logic              is_ctrl,
  output logic              bad,
  output logic              blk6_ok,
  output logic              rd_next
);
  logic [NUM_X-1:0] hit6;
  logic             k28;
  logic [X_W-1:0]   x_idx;
  logic             rd_mid;
  logic [NUM_Y-1:0] dhit, khit;
  logic             alt_hit;
  logic [Y_W-1:0]   y_idx;
  logic [X_W-1:0]   x_out;
  logic             ok;
  logic             need_alt;

  sym10_blk6_match u_b6 (
    .blk(code[CODE_W-1:B4_W]), .rd(rd), .hit(hit6), .k28(k28),
    .idx(x_idx), .rd_mid(rd_mid)
  );

  sym10_blk4_match u_b4 (
    .blk(code[B4_W-1:0]), .rd_mid(rd_mid), .dhit(dhit), .khit(khit),
    .alt_hit(alt_hit)
  );

  assign need_alt = alt_needed(x_idx, rd_mid);

  always_comb begin
    ok      = 1'b0;
    is_ctrl = 1'b0;
    y_idx   = '0;
    x_out   = x_idx;
    if (k28) begin
      x_out   = X_W'(28);
      is_ctrl = 1'b1;
      ok      = |khit;
      for (int j = 0; j < NUM_Y; j++)
        if (khit[j]) y_idx = y_idx | Y_W'(j);
    end else if (|hit6) begin
      if (|dhit[NUM_Y-2:0]) begin
        ok = 1'b1;
        for (int j = 0; j < NUM_Y - 1; j++)
          if (dhit[j]) y_idx = y_idx | Y_W'(j);
      end else if (dhit[NUM_Y-1] && !need_alt) begin
        ok    = 1'b1;
        y_idx = Y_W'(NUM_Y - 1);
      end else if (alt_hit && need_alt) begin
        ok    = 1'b1;
        y_idx = Y_W'(NUM_Y - 1);
      end else if (alt_hit && alt_ctrl_x(x_idx)) begin
        ok      = 1'b1;
        is_ctrl = 1'b1;
        y_idx   = Y_W'(NUM_Y - 1);
      end
    end
  end

  assign value   = {y_idx, x_out};
  assign bad     = !ok;
  assign blk6_ok = k28 || (|hit6);
  // R7: disparity always follows the received bits, flagged or not
  assign rd_next = rd_step4(code[B4_W-1:0], rd_mid);
endmodule

// File: rtl/sym10_decoder.sv
`timescale 1ns/1ps
module sym10_decoder
  import sym10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_ctrl,
  output logic              out_err
);
  logic              rd_q;
  logic [BYTE_W-1:0] dec_value;
  logic              dec_ctrl, dec_bad, dec_blk6_ok, dec_rd_next;
  logic              accept;

  sym10_char_decode u_dec (
    .code(in_code), .rd(rd_q), .value(dec_value), .is_ctrl(dec_ctrl),
    .bad(dec_bad), .blk6_ok(dec_blk6_ok), .rd_next(dec_rd_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= 1'b0;
      out_err   <= 1'b0;
      rd_q      <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        if (raw_mode) begin
          out_ctrl <= in_code[CODE_W-1];
          out_data <= in_code[CODE_W-2:1];
          out_err  <= in_code[0];
        end else begin
          out_ctrl <= dec_ctrl;
          out_data <= dec_value;
          out_err  <= dec_bad;
          rd_q     <= dec_rd_next;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl) && $stable(out_err)));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);

  p_raw_keeps_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && raw_mode) |=> $stable(rd_q));

  p_bad_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !raw_mode && !dec_blk6_ok) |=> out_err);
endmodule

// File: tb/sym10_decoder_test.sv
`timescale 1ns/1ps
module sym10_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0, raw_mode = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [9:0] in_code = '0;
  logic in_ready, out_valid, out_ctrl, out_err;
  logic [7:0] out_data;

  sym10_decoder uut (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_ctrl(out_ctrl), .out_err(out_err)
  );

  always #10 clk = ~clk;

  typedef struct packed { logic [7:0] d; logic k; logic e; logic chk; logic [3:0] req; } exp_t;
  exp_t q[$];
  exp_t cur;
  int checks = 0, errors = 0, bp = 0, gapmax = 0;
  logic took, tx_rd, done = 1'b0;

  task automatic chk(input bit ok, input int req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [5:0] t6(input logic [4:0] x);
    logic [5:0] r;
    case (x)
      0: r=6'b100111; 1: r=6'b011101; 2: r=6'b101101; 3: r=6'b110001;
      4: r=6'b110101; 5: r=6'b101001; 6: r=6'b011001; 7: r=6'b111000;
      8: r=6'b111001; 9: r=6'b100101; 10: r=6'b010101; 11: r=6'b110100;
      12: r=6'b001101; 13: r=6'b101100; 14: r=6'b011100; 15: r=6'b010111;
      16: r=6'b011011; 17: r=6'b100011; 18: r=6'b010011; 19: r=6'b110010;
      20: r=6'b001011; 21: r=6'b101010; 22: r=6'b011010; 23: r=6'b111010;
      24: r=6'b110011; 25: r=6'b100110; 26: r=6'b010110; 27: r=6'b110110;
      28: r=6'b001110; 29: r=6'b101110; 30: r=6'b011110; default: r=6'b101011;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] t4(input logic [2:0] y, input logic k);
    logic [3:0] r;
    if (k) case (y)
      0: r=4'b1011; 1: r=4'b0110; 2: r=4'b1010; 3: r=4'b1100;
      4: r=4'b1101; 5: r=4'b0101; 6: r=4'b1001; default: r=4'b0111;
    endcase
    else case (y)
      0: r=4'b1011; 1: r=4'b1001; 2: r=4'b0101; 3: r=4'b1100;
      4: r=4'b1101; 5: r=4'b1010; 6: r=4'b0110; default: r=4'b1110;
    endcase
    return r;
  endfunction

  // disparity after a received character (R6)
  function automatic logic b_rdrun(input logic [9:0] c, input logic rd);
    int n6, n4;
    logic r;
    r = rd;
    n6 = $countones(c[9:4]);
    if (n6 > 3 || c[9:4] == 6'b000111) r = 1'b1;
    else if (n6 < 3 || c[9:4] == 6'b111000) r = 1'b0;
    n4 = $countones(c[3:0]);
    if (n4 > 2 || c[3:0] == 4'b0011) r = 1'b1;
    else if (n4 < 2 || c[3:0] == 4'b1100) r = 1'b0;
    return r;
  endfunction

  // bench-side encoder: returns {rd_after, code}
  function automatic logic [10:0] b_enc(input logic [7:0] b, input logic k, input logic rd);
    logic [4:0] x; logic [2:0] y; logic [5:0] s6; logic [3:0] s4; logic r1; logic altf;
    x = b[4:0]; y = b[7:5];
    s6 = (k && x == 28) ? 6'b001111 : t6(x);
    if (rd && ($countones(s6) != 3 || s6 == 6'b111000)) s6 = ~s6;
    r1 = b_rdrun({s6, 4'b0101}, rd);
    altf = (y == 7) && ((k && x != 28) || (!r1 && (x == 17 || x == 18 || x == 20)) ||
                        (r1 && (x == 11 || x == 13 || x == 14)));
    if (k && x == 28) s4 = r1 ? ~t4(y, 1'b1) : t4(y, 1'b1);
    else if (altf) s4 = r1 ? 4'b1000 : 4'b0111;
    else begin
      s4 = t4(y, 1'b0);
      if (r1 && ($countones(s4) != 2 || s4 == 4'b1100)) s4 = ~s4;
    end
    return {b_rdrun({s6, s4}, rd), s6, s4};
  endfunction

  task automatic step();
    exp_t e;
    logic f_in, f_out;
    @(negedge clk);
    f_out = out_valid && out_ready;
    f_in  = in_valid && in_ready;
    if (f_out) begin
      if (q.size() == 0) chk(0, 10, "unexpected output", 1, 0);
      else begin
        e = q.pop_front();
        chk(out_err == e.e, e.req, "out_err", out_err, e.e);
        if (e.chk) begin
          chk(out_data == e.d, e.req, "out_data", out_data, e.d);
          chk(out_ctrl == e.k, e.req, "out_ctrl", out_ctrl, e.k);
        end
      end
    end
    if (f_in) q.push_back(cur);
    @(posedge clk); #2;
    took = f_in;
    out_ready = (bp == 0) ? 1'b1 : (bp == 2) ? 1'b0 : ($urandom % 4 != 0);
  endtask

  task automatic send_code(input logic [9:0] c, input logic raw, input exp_t e);
    if (gapmax > 0) repeat ($urandom % (gapmax + 1)) step();
    in_code = c; raw_mode = raw; cur = e; in_valid = 1'b1;
    do step(); while (!took);
    in_valid = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] b, input logic k, input int req);
    logic [10:0] r;
    r = b_enc(b, k, tx_rd);
    tx_rd = r[10];
    send_code(r[9:0], 1'b0, '{d: b, k: k, e: 1'b1 ^ 1'b1, chk: 1'b1, req: 4'(req)});
  endtask

  task automatic send_bad(input logic [9:0] c, input int req);
    tx_rd = b_rdrun(c, tx_rd);
    send_code(c, 1'b0, '{d: 8'h00, k: 1'b0, e: 1'b1, chk: 1'b0, req: 4'(req)});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; raw_mode = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1; tx_rd = 1'b0;
    chk(out_valid == 1'b0, 1, "out_valid after reset", out_valid, 0);   // R1
    chk(in_ready == 1'b1, 10, "in_ready after reset", in_ready, 1);      // R10
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      chk(0, 0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    logic [10:0] r;
    logic [7:0] kl [12];
    void'($urandom(32'd1234));
    // R1: negative start, accepted form
    do_reset();
    send_char(8'h00, 1'b0, 1);
    chk(out_valid == 1'b1, 9, "out_valid one edge after accept", out_valid, 1); // R9
    step();
    // R1: positive form right after reset is flagged
    do_reset();
    r = b_enc(8'h00, 1'b0, 1'b1);
    send_bad(r[9:0], 1);
    step();
    // R2: data values
    send_char(8'hFF, 1'b0, 2); send_char(8'hA5, 1'b0, 2); send_char(8'h5A, 1'b0, 2);
    send_char(8'h17, 1'b0, 2); send_char(8'h3C, 1'b0, 2);
    // R6: special balanced blocks and alternate y=7 forms
    send_char(8'h67, 1'b0, 6); send_char(8'h67, 1'b0, 6); send_char(8'h00, 1'b0, 6);
    send_char(8'h67, 1'b0, 6); send_char(8'hF1, 1'b0, 6); send_char(8'hEB, 1'b0, 6);
    send_char(8'hF4, 1'b0, 6); send_char(8'hED, 1'b0, 6); send_char(8'h23, 1'b0, 6);
    // R3: all control characters, twice for both disparities
    kl = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
    for (int i = 0; i < 24; i++) send_char(kl[i % 12], 1'b1, 3);
    // R4: illegal patterns
    send_bad(10'b0000000000, 4); send_bad(10'b1111111111, 4);
    send_bad({6'b111111, 4'b0101}, 4);
    r = b_enc(8'h00, 1'b0, tx_rd);
    send_bad({r[9:4], 4'b1111}, 4);
    // R7: recovery after the flag
    send_char(8'hBC, 1'b1, 7); send_char(8'h4A, 1'b0, 7); send_char(8'h00, 1'b0, 7);
    // R5: late disparity detection after a flipped bit
    if (tx_rd) send_char(8'h20, 1'b0, 5);
    send_code(10'b1010101011, 1'b0, '{d: 8'h15, k: 1'b0, e: 1'b0, chk: 1'b1, req: 4'd5});
    send_code(10'b0101010101, 1'b0, '{d: 8'h4A, k: 1'b0, e: 1'b0, chk: 1'b1, req: 4'd5});
    tx_rd = 1'b1;
    send_bad(10'b1001110100, 5);
    send_char(8'h20, 1'b0, 7);
    // R8 and R11: raw pass-through keeps disparity
    send_code(10'b1011001101, 1'b1, '{d: 8'h66, k: 1'b1, e: 1'b1, chk: 1'b1, req: 4'd8});
    send_code(10'b0110011000, 1'b1, '{d: 8'hCC, k: 1'b0, e: 1'b0, chk: 1'b1, req: 4'd8});
    send_code(10'b0000000000, 1'b1, '{d: 8'h00, k: 1'b0, e: 1'b0, chk: 1'b1, req: 4'd11});
    send_char(8'h00, 1'b0, 11); send_char(8'h07, 1'b0, 11);
    send_code(10'b1111111111, 1'b1, '{d: 8'hFF, k: 1'b1, e: 1'b1, chk: 1'b1, req: 4'd11});
    send_char(8'h00, 1'b0, 11); send_char(8'h1F, 1'b0, 11);
    step();
    // R10: stall holds the output and blocks input
    bp = 2; out_ready = 1'b0;
    send_char(8'h81, 1'b0, 10);
    held = out_data;
    in_code = 10'b1001110100; in_valid = 1'b1; cur = '{d: 8'h00, k: 1'b0, e: 1'b0, chk: 1'b1, req: 4'd10};
    for (int i = 0; i < 3; i++) begin
      step();
      chk(took == 1'b0, 10, "accepted while stalled", took, 0);
      chk(out_valid == 1'b1 && out_data == held, 10, "held output", out_data, held);
      chk(in_ready == 1'b0, 10, "in_ready while stalled", in_ready, 0);
    end
    in_valid = 1'b0; bp = 0; out_ready = 1'b1;
    step(); step();
    // random traffic with back-pressure and injected errors (R2 R3 R4 R7 R10)
    bp = 1; gapmax = 2;
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom % 100;
      if (sel < 8) send_char(kl[$urandom % 12], 1'b1, 3);
      else if (sel < 10) send_bad({6'b111111, 4'($urandom)}, 4);
      else if (sel < 12) send_bad({6'($urandom), 4'b0000}, 7);
      else send_char(8'($urandom), 1'b0, 2);
    end
    bp = 0; gapmax = 0; out_ready = 1'b1;
    repeat (6) step();
    chk(q.size() == 0, 10, "characters left undelivered", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule